// File: doc/BRIEF.md
# Soft-Off Exit Watchdog with Bounded Recovery

This block supervises the interval after a power-up attempt has started, during which the platform is expected to leave its deepest soft-off sleep level. It watches an active-low deep-sleep indication. The indication counts as released when the level goes high. All timing is counted on a slow tick enable, nominally one pulse per millisecond.

If the release arrives in time, the block reports that sequencing may advance to the next stage, and it forgets any earlier failures. If the wait expires, the block runs a recovery sequence:
- it first forces every supply rail off;
- it then pulses a real-time-clock clear output;
- it lets the platform settle for a short delay;
- it then asks for a fresh power-up attempt.

After too many consecutive failures, it skips the settle delay and asks the platform to remain off. Each outcome is a code that is present for exactly one clock cycle. After that the block sits idle until the next start strobe.

Top module: `softoff_exit_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, the rail-kill and clock-clear outputs are low and the result code is 2'b00 (none).
- R2: The deep-sleep level passes through two flops before it is used. A rise at the input shows up as result 2'b01 in the third cycle after the rise and not earlier.
- R3: In the waiting phase, a synchronized high level produces result 2'b01 (advance) and clears the failure count.
- R4: If TIMEOUT_TICKS tick-enabled cycles pass in the waiting phase without release, rail-kill rises alone for one cycle, and the clock-clear output rises in the following cycle.
- R5: Clock-clear stays high for PULSE_TICKS tick-enabled cycles, and rail-kill is held high throughout.
- R6: When the failure count is not above MAX_RETRIES, the pulse is followed by a settle phase of SETTLE_TICKS tick-enabled cycles, still with rail-kill high. Then result 2'b10 (retry) is reported and rail-kill drops.
- R7: On the timeout that brings the consecutive failure count above MAX_RETRIES (the fifth by default), result 2'b11 (stay off) is reported directly after the pulse, and the count returns to zero.
- R8: Any non-zero result lasts one cycle and is followed by 2'b00. The block then stays idle with both outputs low until a start strobe.
- R9: A start strobe that arrives while a supervision is running is ignored. The deep-sleep level is ignored outside the waiting phase.
- R10: The timers advance only in cycles where the tick enable is high. With the tick held low, no timeout ever occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle strobe that begins a supervision |
| deepSleepN | input | 1 | Active-low deep-sleep level, asynchronous to clk |
| tickEn | input | 1 | Timebase enable, one cycle per tick |
| railsKill | output | 1 | Forces all supply rails off |
| rtcClear | output | 1 | Real-time-clock clear pulse |
| resultCode | output | 2 | 00 none, 01 advance, 10 retry, 11 stay off; valid for one cycle |

## Verification
The hardest state to reach is the fifth consecutive failure. It only counts when no release has arrived in between. The bench has to string together a run of full timeout, pulse and settle cycles, and it also has to show that an earlier release reset the count. The stimulus first builds up two failures and then lets one release succeed. After that it drives five further unanswered attempts. The stay-off code may appear only on the last of these. Along the way the bench raises the deep-sleep level during a settle phase and strobes start in the middle of a wait. Neither may change the outcome.

// File: rtl/softoff_pkg.sv
package softoff_pkg;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_ADVANCE = 2'b01,
    RES_RETRY   = 2'b10,
    RES_STAYOFF = 2'b11
  } result_e;

  typedef enum logic [1:0] {
    LIM_WAIT   = 2'd0,
    LIM_PULSE  = 2'd1,
    LIM_SETTLE = 2'd2
  } limit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    cntClr;
    logic    cntInc;   // count when the tick enable is high
    logic    attInc;
    logic    attClr;
    logic    resLoad;
    result_e resCode;
    limit_e  limitSel;
  } ctrl_s;

endpackage

// File: rtl/softoff_sync.sv
module softoff_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/softoff_datapath.sv
module softoff_datapath
  import softoff_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 4000,
  parameter int PULSE_TICKS   = 1,
  parameter int SETTLE_TICKS  = 10,
  parameter int MAX_RETRIES   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  logic    levelIn,
  input  ctrl_s   ctrl,
  output logic    levelHigh,
  output logic    lastTick,
  output logic    overCap,
  output result_e resultQ
);
  localparam int MAX_A  = (TIMEOUT_TICKS > PULSE_TICKS) ? TIMEOUT_TICKS : PULSE_TICKS;
  localparam int MAXLIM = (MAX_A > SETTLE_TICKS) ? MAX_A : SETTLE_TICKS;
  localparam int CNT_W  = (MAXLIM > 1) ? $clog2(MAXLIM + 1) : 1;
  localparam int ATT_W  = $clog2(MAX_RETRIES + 2);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limitM1;
  logic [ATT_W-1:0] attempts;

  softoff_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(levelIn), .syncOut(levelHigh)
  );

  always_comb begin
    case (ctrl.limitSel)
      LIM_PULSE:  limitM1 = CNT_W'(PULSE_TICKS - 1);
      LIM_SETTLE: limitM1 = CNT_W'(SETTLE_TICKS - 1);
      default:    limitM1 = CNT_W'(TIMEOUT_TICKS - 1);
    endcase
  end

  assign lastTick = tickEn && (tickCnt == limitM1);
  assign overCap  = attempts > ATT_W'(MAX_RETRIES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      attempts <= '0;
      resultQ  <= RES_NONE;
    end else begin
      if (ctrl.cntClr)                tickCnt <= '0;
      else if (ctrl.cntInc && tickEn) tickCnt <= tickCnt + 1'b1;

      if (ctrl.attClr)      attempts <= '0;
      else if (ctrl.attInc) attempts <= attempts + 1'b1;

      resultQ <= ctrl.resLoad ? ctrl.resCode : RES_NONE;
    end
  end

  // R8: a result is a one-cycle event
  assert_one_cycle_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resultQ != RES_NONE) |=> (resultQ == RES_NONE));

  // R3: an advance is only reported after a synchronized release
  assert_advance_needs_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resultQ == RES_ADVANCE) |-> $past(levelHigh));

  // R7: giving up leaves the failure count empty
  assert_stayoff_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resultQ == RES_STAYOFF) |-> (attempts == '0));

  // R7: the count never passes the cap by more than one
  assert_attempts_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    attempts <= ATT_W'(MAX_RETRIES + 1));
endmodule

// File: rtl/softoff_control.sv
module softoff_control
  import softoff_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    levelHigh,
  input  logic    lastTick,
  input  logic    overCap,
  input  result_e resultIn,
  output ctrl_s   ctrl,
  output logic    railsKill,
  output logic    rtcClear
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_KILL, ST_PULSE, ST_SETTLE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '{cntClr: 1'b0, cntInc: 1'b0, attInc: 1'b0, attClr: 1'b0,
                  resLoad: 1'b0, resCode: RES_NONE, limitSel: LIM_WAIT};
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          ctrl.cntClr = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        ctrl.limitSel = LIM_WAIT;
        if (levelHigh) begin
          ctrl.resLoad = 1'b1;
          ctrl.resCode = RES_ADVANCE;
          ctrl.attClr  = 1'b1;
          stateNext    = ST_IDLE;
        end else if (lastTick) begin
          ctrl.cntClr = 1'b1;
          ctrl.attInc = 1'b1;
          stateNext   = ST_KILL;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_KILL: begin
        ctrl.cntClr = 1'b1;
        stateNext   = ST_PULSE;
      end
      ST_PULSE: begin
        ctrl.limitSel = LIM_PULSE;
        if (lastTick) begin
          ctrl.cntClr = 1'b1;
          if (overCap) begin
            ctrl.resLoad = 1'b1;
            ctrl.resCode = RES_STAYOFF;
            ctrl.attClr  = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            stateNext = ST_SETTLE;
          end
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      ST_SETTLE: begin
        ctrl.limitSel = LIM_SETTLE;
        if (lastTick) begin
          ctrl.resLoad = 1'b1;
          ctrl.resCode = RES_RETRY;
          stateNext    = ST_IDLE;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign railsKill = (state == ST_KILL) || (state == ST_PULSE) || (state == ST_SETTLE);
  assign rtcClear  = (state == ST_PULSE);

  // R4: the rails are already forced off when the clock clear starts
  assert_off_precedes_rtc_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtcClear) |-> $past(railsKill));

  // R6: rail-kill only drops together with a retry or stay-off result
  assert_release_with_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(railsKill) |-> (resultIn == RES_RETRY || resultIn == RES_STAYOFF));

  // R9: a supervision never restarts from the middle of recovery
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE && startPulse && !lastTick) |=> (state == ST_SETTLE));
endmodule

// File: rtl/softoff_exit_guard.sv
module softoff_exit_guard
  import softoff_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 4000,
  parameter int PULSE_TICKS   = 1,
  parameter int SETTLE_TICKS  = 10,
  parameter int MAX_RETRIES   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       deepSleepN,
  input  logic       tickEn,
  output logic       railsKill,
  output logic       rtcClear,
  output logic [1:0] resultCode
);
  ctrl_s   ctrl;
  logic    levelHigh;
  logic    lastTick;
  logic    overCap;
  result_e resultQ;

  softoff_datapath #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS), .PULSE_TICKS(PULSE_TICKS),
    .SETTLE_TICKS(SETTLE_TICKS), .MAX_RETRIES(MAX_RETRIES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .levelIn(deepSleepN),
    .ctrl(ctrl), .levelHigh(levelHigh), .lastTick(lastTick),
    .overCap(overCap), .resultQ(resultQ)
  );

  softoff_control i_ctl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .levelHigh(levelHigh),
    .lastTick(lastTick), .overCap(overCap), .resultIn(resultQ),
    .ctrl(ctrl), .railsKill(railsKill), .rtcClear(rtcClear)
  );

  assign resultCode = resultQ;
endmodule

// File: tb/test_softoff_exit_guard.sv
module test_softoff_exit_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TO  = 20;
  localparam int PW  = 3;
  localparam int ST  = 5;
  localparam int CAP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startDrv = 1'b0;
  logic slpDrv = 1'b0;
  logic tickEn = 1'b0;
  logic tickGate = 1'b1;
  logic railsKill, rtcClear;
  logic [1:0] resultCode;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  // behavioural reference state
  int mPhase = 0, mCnt = 0, mAtt = 0, mRes = 0, mS1 = 0, mS2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softoff_exit_guard #(
    .TIMEOUT_TICKS(TO), .PULSE_TICKS(PW), .SETTLE_TICKS(ST), .MAX_RETRIES(CAP)
  ) i_softoff_exit_guard (
    .clk(clk), .rstN(rstN), .startPulse(startDrv), .deepSleepN(slpDrv),
    .tickEn(tickEn), .railsKill(railsKill), .rtcClear(rtcClear),
    .resultCode(resultCode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tickEn <= tickGate && (cyc % 3 == 0);
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mAtt = 0; mRes = 0; mS1 = 0; mS2 = 0;
    end else begin
      int lvl;
      lvl  = mS2;
      mS2  = mS1;
      mS1  = slpDrv;
      mRes = 0;
      case (mPhase)
        0: if (startDrv) begin mPhase = 1; mCnt = 0; end
        1: begin
          if (lvl != 0) begin mRes = 1; mAtt = 0; mPhase = 0; end
          else if (tickEn) begin
            if (mCnt == TO-1) begin mPhase = 2; mCnt = 0; mAtt++; end
            else mCnt++;
          end
        end
        2: mPhase = 3;
        3: if (tickEn) begin
          if (mCnt == PW-1) begin
            mCnt = 0;
            if (mAtt > CAP) begin mRes = 3; mAtt = 0; mPhase = 0; end
            else mPhase = 4;
          end else mCnt++;
        end
        4: if (tickEn) begin
          if (mCnt == ST-1) begin mRes = 2; mPhase = 0; end
          else mCnt++;
        end
        default: mPhase = 0;
      endcase
    end
  end

  // every-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int expKill, expRtc;
      expKill = (mPhase >= 2) ? 1 : 0;
      expRtc  = (mPhase == 3) ? 1 : 0;
      check(railsKill == expKill, "R4 rail-kill", railsKill, expKill);
      check(rtcClear == expRtc, "R5 clock-clear", rtcClear, expRtc);
      check(resultCode == mRes, "R8 result", resultCode, mRes);
    end
  end

  task automatic pulseStart();
    @(negedge clk); startDrv = 1'b1;
    @(negedge clk); startDrv = 1'b0;
  endtask

  task automatic waitResult(input int expCode, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (resultCode != 2'b00) seen = 1'b1;
    end
    check(seen && resultCode == expCode, tag, resultCode, expCode);
    @(negedge clk);
    check(resultCode == 2'b00, "R8 one-cycle result", resultCode, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(railsKill == 0 && rtcClear == 0, "R1 outputs in reset", railsKill, 0);
    check(resultCode == 0, "R1 result in reset", resultCode, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(railsKill == 0 && rtcClear == 0 && resultCode == 0, "R1 after reset", resultCode, 0);

    // R3: quick release gives advance
    pulseStart();
    repeat (5) @(negedge clk);
    slpDrv = 1'b1;
    waitResult(1, "R3 advance");
    slpDrv = 1'b0;
    repeat (20) @(negedge clk);
    check(railsKill == 0 && resultCode == 0, "R8 stays idle", railsKill, 0);

    // R10: no ticks, no timeout; then a retry (count 1)
    tickGate = 1'b0;
    pulseStart();
    repeat (300) @(negedge clk);
    check(railsKill == 0, "R10 frozen timer", railsKill, 0);
    tickGate = 1'b1;
    waitResult(2, "R6 retry after stall");

    // R4: kill alone for a cycle, then clock-clear (count 2)
    pulseStart();
    for (int i = 0; i < 500 && railsKill == 0; i++) @(negedge clk);
    check(rtcClear == 0, "R4 kill before clear", rtcClear, 0);
    @(negedge clk);
    check(rtcClear == 1, "R4 clear follows kill", rtcClear, 1);
    check(railsKill == 1, "R5 kill held in pulse", railsKill, 1);
    waitResult(2, "R6 retry");

    // R2: release timing through the synchronizer; clears the count (R3)
    pulseStart();
    repeat (4) @(negedge clk);
    slpDrv = 1'b1;
    @(negedge clk);
    check(resultCode == 0, "R2 not after one cycle", resultCode, 0);
    @(negedge clk);
    check(resultCode == 0, "R2 not after two cycles", resultCode, 0);
    @(negedge clk);
    check(resultCode == 1, "R2 advance on third cycle", resultCode, 1);
    slpDrv = 1'b0;
    repeat (5) @(negedge clk);

    // five unanswered attempts: four retries then stay-off (R3 cleared count, R7)
    for (int k = 1; k <= 5; k++) begin
      pulseStart();
      if (k == 1) begin
        repeat (10) @(negedge clk);
        pulseStart(); // R9: ignored while waiting
        for (int i = 0; i < 500 && rtcClear == 0; i++) @(negedge clk);
        for (int i = 0; i < 500 && rtcClear == 1; i++) @(negedge clk);
        slpDrv = 1'b1; // R9: ignored during settle
        pulseStart();
        @(negedge clk);
        check(railsKill == 1 && resultCode == 0, "R9 settle unaffected", railsKill, 1);
        slpDrv = 1'b0;
      end
      if (k < 5) waitResult(2, "R7 retry below cap");
      else       waitResult(3, "R7 stay-off at cap");
    end
    check(railsKill == 0 && rtcClear == 0, "R7 outputs released", railsKill, 0);

    // count cleared after giving up: next failure is a retry again
    pulseStart();
    waitResult(2, "R7 count cleared");

    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule